// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block holds the micro-program counter of a multicycle control unit and works out, once per clock, which control-store word comes next. The current microinstruction supplies a two-bit sequencing code, a condition-enable bit, a condition-select bit and a branch target field. The instruction register supplies the opcode. The datapath supplies two status lines: arithmetic overflow and a pending interrupt.

In normal operation the sequencer does one of three things. It returns to the fetch word at address 0. It jumps through an opcode dispatch table to the first word of the instruction's routine. Or it steps to the following word. Any opcode the table does not know is sent to the reserved-instruction exception routine.

A conditional micro-branch lets a microinstruction leave for exception microcode. When the microinstruction enables a test and the selected status line is high, the branch target replaces the normal choice. The micro-address is held in a register, so it reaches the control store straight from a flop.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `uaddr` becomes 0 after that edge. This also holds when `rst` is raised in the middle of operation.
- R2: With no micro-branch taken, sequencing code 2'b00 makes the next `uaddr` 0.
- R3: With no micro-branch taken, sequencing code 2'b01 loads the dispatch entry for the current `opcode` into `uaddr`. The entries are: 6'b000000 → 4, 6'b000100 → 3, 6'b001101 → 6, 6'b100011 → 8, 6'b101011 → 11.
- R4: With no micro-branch taken, sequencing code 2'b01 with any opcode not listed in R3 makes the next `uaddr` 12, the reserved-instruction routine.
- R5: With no micro-branch taken, sequencing code 2'b10 makes the next `uaddr` the current value plus 1, wrapping from 15 to 0.
- R6: Sequencing code 2'b11 acts exactly like 2'b00.
- R7: When `cond_en` is 1 and the selected condition is 1, the next `uaddr` equals `br_target`, whatever the sequencing code. `cond_sel` = 0 selects `ovf`, and `cond_sel` = 1 selects `irq_pend`.
- R8: The condition not chosen by `cond_sel` has no effect on the next `uaddr`. While `cond_en` is 0, neither condition has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seq_code | input | 2 | Sequencing code of the current microinstruction |
| opcode | input | 6 | Opcode field of the instruction register |
| cond_en | input | 1 | Microinstruction requests a conditional micro-branch |
| cond_sel | input | 1 | Condition to test: 0 = overflow, 1 = pending interrupt |
| br_target | input | 4 | Micro-branch destination address |
| ovf | input | 1 | Arithmetic overflow from the datapath |
| irq_pend | input | 1 | Pending interrupt flag |
| uaddr | output | 4 | Registered micro-address driving the control store |

## Verification
The bench builds the block with its default parameters: a 4-bit micro-address and a 6-bit opcode. With these values all sixteen micro-addresses can be reached in a short run. This includes the wrap from 15 back to 0 and the reserved-instruction entry at 12. Every one of the 64 opcodes can also be driven through the dispatch path. Random stimulus then mixes sequencing codes, condition selections and target values, so the branch override and the ignored-condition cases occur at many different micro-PC values.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP  = 2'b01,
    SEQ_STEP  = 2'b10,
    SEQ_RSVD  = 2'b11
  } seq_code_e;

  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int UA_W = 4,
  parameter logic [UA_W-1:0] T_RTYPE = 4,
  parameter logic [UA_W-1:0] T_BEQ   = 3,
  parameter logic [UA_W-1:0] T_ORI   = 6,
  parameter logic [UA_W-1:0] T_LW    = 8,
  parameter logic [UA_W-1:0] T_SW    = 11,
  parameter logic [UA_W-1:0] T_RSVD  = 12
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  target
);
  always_comb begin
    unique case (opcode)
      OPC_RTYPE: target = T_RTYPE;
      OPC_BEQ:   target = T_BEQ;
      OPC_ORI:   target = T_ORI;
      OPC_LW:    target = T_LW;
      OPC_SW:    target = T_SW;
      default:   target = T_RSVD;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UA_W = 4
) (
  input  logic [1:0]      seq_code,
  input  logic [UA_W-1:0] cur,
  input  logic [UA_W-1:0] disp_tgt,
  input  logic            cond_en,
  input  logic            cond_sel,
  input  logic            ovf,
  input  logic            irq_pend,
  input  logic [UA_W-1:0] br_target,
  output logic [UA_W-1:0] nxt
);
  localparam logic [UA_W-1:0] ONE = {{(UA_W-1){1'b0}}, 1'b1};

  logic [1:0] cond_vec;
  logic       take_br;
  logic [UA_W-1:0] seq_nxt;

  assign cond_vec = {irq_pend, ovf};
  assign take_br  = cond_en & cond_vec[cond_sel];

  always_comb begin
    case (seq_code_e'(seq_code))
      SEQ_DISP: seq_nxt = disp_tgt;
      SEQ_STEP: seq_nxt = cur + ONE;
      default:  seq_nxt = '0;
    endcase
  end

  assign nxt = take_br ? br_target : seq_nxt;
endmodule

// File: rtl/useq_upc.sv
module useq_upc #(
  parameter int UA_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [UA_W-1:0] nxt,
  output logic [UA_W-1:0] upc
);
  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int UA_W = 4,
  parameter logic [UA_W-1:0] RSVD_ADDR = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      seq_code,
  input  logic [5:0]      opcode,
  input  logic            cond_en,
  input  logic            cond_sel,
  input  logic [UA_W-1:0] br_target,
  input  logic            ovf,
  input  logic            irq_pend,
  output logic [UA_W-1:0] uaddr
);
  logic [UA_W-1:0] disp_tgt;
  logic [UA_W-1:0] nxt;

  useq_dispatch #(.UA_W(UA_W), .T_RSVD(RSVD_ADDR)) u_disp (
    .opcode(opcode),
    .target(disp_tgt)
  );

  useq_next #(.UA_W(UA_W)) u_next (
    .seq_code(seq_code), .cur(uaddr), .disp_tgt(disp_tgt),
    .cond_en(cond_en), .cond_sel(cond_sel), .ovf(ovf),
    .irq_pend(irq_pend), .br_target(br_target), .nxt(nxt)
  );

  useq_upc #(.UA_W(UA_W)) u_upc (
    .clk(clk), .rst(rst), .nxt(nxt), .upc(uaddr)
  );

  // R1: reset forces fetch address
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> uaddr == '0);

  // R7: selected condition true overrides sequencing
  a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_en) && ($past(cond_sel) ? $past(irq_pend) : $past(ovf)))
    |-> uaddr == $past(br_target));

  // R2 / R6: fetch and reserved codes return to 0 when no branch
  a_r2_fetch_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cond_en) && ($past(seq_code) == 2'b00 || $past(seq_code) == 2'b11))
    |-> uaddr == '0);

  // R5: step code advances by one
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cond_en) && $past(seq_code) == 2'b10)
    |-> uaddr == $past(uaddr) + 1'b1);

  // R4: unknown opcode reaches reserved-instruction routine
  a_r4_reserved: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cond_en) && $past(seq_code) == 2'b01 &&
     $past(opcode) == 6'b111111)
    |-> uaddr == RSVD_ADDR);
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] seq_code;
  logic [5:0] opcode;
  logic       cond_en, cond_sel, ovf, irq_pend;
  logic [3:0] br_target;
  logic [3:0] uaddr;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst(rst), .seq_code(seq_code), .opcode(opcode),
    .cond_en(cond_en), .cond_sel(cond_sel), .br_target(br_target),
    .ovf(ovf), .irq_pend(irq_pend), .uaddr(uaddr)
  );

  function automatic int disp_of(input int op);
    case (op)
      0:  return 4;
      4:  return 3;
      13: return 6;
      35: return 8;
      43: return 11;
      default: return 12;
    endcase
  endfunction

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(uaddr) != exp) begin
      fails++;
      $display("FAIL %s: uaddr=%0d expected=%0d", req, uaddr, exp);
    end
  endtask

  // drive one microinstruction at negedge, compare at following negedge
  task automatic step(input int sc, input int op, input bit en, input bit sel,
                      input bit ov, input bit iq, input int tgt);
    int exp;
    string req;
    seq_code = sc[1:0]; opcode = op[5:0]; cond_en = en; cond_sel = sel;
    ovf = ov; irq_pend = iq; br_target = tgt[3:0];
    if (en && (sel ? iq : ov)) begin exp = tgt; req = "R7"; end
    else begin
      case (sc)
        1: begin exp = disp_of(op); req = (exp == 12) ? "R4" : "R3"; end
        2: begin exp = (model + 1) % 16; req = "R5"; end
        3: begin exp = 0; req = "R6"; end
        default: begin exp = 0; req = "R2"; end
      endcase
      if (ov || iq) req = {req, "/R8"};
    end
    @(posedge clk); @(negedge clk);
    check(req, exp);
    model = exp;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: uaddr=%0d expected=finished", uaddr);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; seq_code = 2; opcode = 0; cond_en = 0; cond_sel = 0;
    ovf = 0; irq_pend = 0; br_target = 0;
    repeat (3) @(negedge clk);
    check("R1", 0);
    rst = 0; model = 0;
    // R5: walk through all addresses and wrap
    for (int i = 0; i < 17; i++) step(2, 0, 0, 0, 0, 0, 0);
    // R3: each dispatch entry
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0, 0);
    step(1, 13, 0, 0, 0, 0, 0);
    step(1, 35, 0, 0, 0, 0, 0);
    step(1, 43, 0, 0, 0, 0, 0);
    // R4: every unlisted opcode
    for (int op = 0; op < 64; op++) step(1, op, 0, 0, 0, 0, 0);
    // R2 and R6
    step(2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(2, 0, 0, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0, 0);
    // R7: overflow branch, interrupt branch
    step(2, 0, 1, 0, 1, 0, 13);
    step(1, 35, 1, 1, 0, 1, 14);
    // R8: unselected condition and disabled test ignored
    step(2, 0, 1, 0, 0, 1, 9);
    step(2, 0, 1, 1, 1, 0, 9);
    step(1, 43, 0, 0, 1, 1, 7);
    // R1: reset in mid-run
    step(2, 0, 0, 0, 0, 0, 0);
    rst = 1; @(posedge clk); @(negedge clk);
    check("R1", 0); rst = 0; model = 0;
    // mixed random stimulus
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3), $urandom_range(0, 63), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 15));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule